// File: doc/BRIEF.md
# Sine Tune Sequencer

This block plays a fixed sixteen-note tune as a stream of 8-bit sine samples for an external parallel DAC. A one-cycle start request begins playback from the first note. Every note lasts a fixed number of system cycles. During a note, a divider paced by that note's entry in a table of half-period counts steps a phase address through a 256-entry sine table. The result is one full sine period for every 256 address steps, at the pitch the table entry sets.

The waveform table is computed at elaboration. It holds one full period centred on 100 with a swing of 100, so every value lies between 0 and 200. While nothing plays, the output rests at the mid value 100. When the sixteenth note ends, the block drops its busy flag and raises a one-cycle done pulse.

Top module: `sine_tune_top`

## Requirements
- R1: While reset is held and after it releases, busy is 0, done is 0 and the sample output is 100.
- R2: A start input sampled high at a clock edge makes busy 1 after that edge, selects note 0 and clears the phase address, so the sample is 100 (table entry 0).
- R3: Table entry k equals 100 + 100*sin(2*pi*k/256), rounded to an integer, to within one LSB. Entry 64 is exactly 200, entries 0 and 128 are exactly 100, entry 192 is exactly 0, and no entry exceeds 200.
- R4: During note n, the phase address advances by one every 2*HALF_DIV[n] cycles. After the note starts, address k is shown from cycle 2*HALF_DIV[n]*k onward. 256 steps (512*HALF_DIV[n] cycles) make one full period, and then the pattern repeats.
- R5: Over the first quarter period (addresses 0 to 64), the samples never decrease.
- R6: Each note lasts exactly NOTE_CYCLES cycles. Note n+1 starts NOTE_CYCLES cycles after note n, with the phase address back at 0. The notes play in table order 0 to 15.
- R7: On the edge that ends note 15 (16*NOTE_CYCLES cycles after start), busy falls, the sample returns to 100 and done is 1 for exactly one cycle. Done is never 1 while busy.
- R8: A start during playback restarts at note 0 with the phase address at 0, at the pitch of note 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin, or restart, the tune |
| sample | output | 8 | Unsigned sample to the DAC |
| busy | output | 1 | Tune in progress |
| done | output | 1 | One-cycle pulse when the tune ends |

## Verification
All results are counted in clock edges from the start edge, which is offset zero. The sample for phase address k of note n is due at offset n*NOTE_CYCLES + 2*HALF_DIV[n]*k. The end-of-tune flags are due at offset 16*NOTE_CYCLES. The bench keeps a running edge offset and reads the outputs only on falling edges. At each note it checks both the cycle just before a step is due and the cycle of the step itself, so a result that arrives one cycle early or late is caught. The bench shortens the note length and the divider values so that every note can hold more than one full period.

// File: rtl/sine_tune_pkg.sv
package sine_tune_pkg;
  localparam int NOTE_COUNT = 16;
  localparam int NOTE_W     = $clog2(NOTE_COUNT);
  localparam int SAMPLE_W   = 8;
  localparam int PHASE_W    = 8;
  localparam int TABLE_LEN  = 1 << PHASE_W;
  localparam int HALF_LEN   = TABLE_LEN / 2;
  localparam int MID_LEVEL  = 100;
  localparam int SWING      = 100;

  typedef logic [SAMPLE_W-1:0] waveT [TABLE_LEN];

  // strobes from note control to the waveform datapath
  typedef struct packed {
    logic              restart;
    logic              run;
    logic [NOTE_W-1:0] noteSel;
    logic [NOTE_W-1:0] noteCur;
  } ctlT;

  // rational half-wave approximation: s = 16p / (5H^2 - 4p), p = t(H - t)
  function automatic waveT buildWave();
    waveT w;
    for (int k = 0; k < TABLE_LEN; k++) begin
      int t, p, den, mag;
      t   = k % HALF_LEN;
      p   = t * (HALF_LEN - t);
      den = 5 * HALF_LEN * HALF_LEN - 4 * p;
      mag = (2 * SWING * 16 * p + den) / (2 * den);
      if (k < HALF_LEN) w[k] = SAMPLE_W'(MID_LEVEL + mag);
      else              w[k] = SAMPLE_W'(MID_LEVEL - mag);
    end
    return w;
  endfunction
endpackage

// File: rtl/sine_tune_ctrl.sv
module sine_tune_ctrl
  import sine_tune_pkg::*;
#(
  parameter int NOTE_CYCLES = 15_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctlT  ctl,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(NOTE_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NOTE_CYCLES - 1);
  localparam logic [NOTE_W-1:0] LAST_NOTE = NOTE_W'(NOTE_COUNT - 1);

  logic [CNT_W-1:0]  durCnt;
  logic [NOTE_W-1:0] noteIdx;
  logic              noteEnd;

  assign noteEnd = busy && (durCnt == LAST_CNT);

  always_comb begin
    ctl.restart = start || (noteEnd && (noteIdx != LAST_NOTE));
    ctl.run     = busy;
    ctl.noteSel = start ? '0 : noteIdx + 1'b1;
    ctl.noteCur = noteIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      durCnt  <= '0;
      noteIdx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        durCnt  <= '0;
        noteIdx <= '0;
      end else if (noteEnd) begin
        durCnt <= '0;
        if (noteIdx == LAST_NOTE) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          noteIdx <= '0;
        end else begin
          noteIdx <= noteIdx + 1'b1;
        end
      end else if (busy) begin
        durCnt <= durCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sine_tune_dp.sv
module sine_tune_dp
  import sine_tune_pkg::*;
#(
  parameter int          DIV_W = 16,
  parameter int unsigned HALF_DIV [NOTE_COUNT] = '{default: 93}
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlT                 ctl,
  input  logic                busy,
  output logic [SAMPLE_W-1:0] sample
);
  localparam waveT WAVE = buildWave();

  logic [DIV_W-1:0]   divCnt;
  logic               halfPhase;
  logic [PHASE_W-1:0] phaseAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt    <= '0;
      halfPhase <= 1'b0;
      phaseAddr <= '0;
    end else if (ctl.restart) begin
      divCnt    <= DIV_W'(HALF_DIV[ctl.noteSel] - 1);
      halfPhase <= 1'b0;
      phaseAddr <= '0;
    end else if (ctl.run) begin
      if (divCnt == '0) begin
        divCnt    <= DIV_W'(HALF_DIV[ctl.noteCur] - 1);
        halfPhase <= ~halfPhase;
        if (halfPhase) phaseAddr <= phaseAddr + 1'b1;
      end else begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end

  assign sample = busy ? WAVE[phaseAddr] : SAMPLE_W'(MID_LEVEL);
endmodule

// File: rtl/sine_tune_top.sv
module sine_tune_top
  import sine_tune_pkg::*;
#(
  parameter int          NOTE_CYCLES = 15_000_000,
  parameter int          DIV_W       = 16,
  parameter int unsigned HALF_DIV [NOTE_COUNT] =
    '{93, 74, 62, 74, 93, 111, 93, 83, 70, 83, 99, 83, 93, 62, 74, 93}
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic [7:0] sample,
  output logic       busy,
  output logic       done
);
  ctlT ctl;

  sine_tune_ctrl #(.NOTE_CYCLES(NOTE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .busy(busy), .done(done)
  );

  sine_tune_dp #(.DIV_W(DIV_W), .HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .sample(sample)
  );
endmodule

// File: rtl/sine_tune_check.sv
module sine_tune_check (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [7:0] sample,
  input logic       busy,
  input logic       done
);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r1_idle_mid: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sample == 8'd100);
  a_r3_range: assert property (@(posedge clk) disable iff (!rstN)
    sample <= 8'd200);
  a_r2_start_begin: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy && sample == 8'd100);
endmodule

bind sine_tune_top sine_tune_check u_check (
  .clk(clk), .rstN(rstN), .start(start), .sample(sample), .busy(busy), .done(done)
);

// File: tb/test_sine_tune_top.sv
module test_sine_tune_top;
  localparam int NC = 2200;
  localparam int unsigned DIVS [16] = '{1, 2, 3, 4, 2, 1, 3, 4, 4, 3, 2, 1, 2, 3, 4, 1};

  logic       clk = 1'b0;
  logic       rstN;
  logic       start;
  logic [7:0] sample;
  logic       busy;
  logic       done;

  int nChecks = 0;
  int nFail   = 0;
  int t       = 0;

  always #4 clk = ~clk;

  sine_tune_top #(.NOTE_CYCLES(NC), .DIV_W(8), .HALF_DIV(DIVS)) i_sine_tune_top (
    .clk(clk), .rstN(rstN), .start(start), .sample(sample), .busy(busy), .done(done)
  );

  function automatic int expWave(int k);
    real v;
    v = 100.0 + 100.0 * $sin(2.0 * 3.14159265358979 * real'(k % 256) / 256.0);
    return $rtoi(v + 0.5);
  endfunction

  task automatic check(string tag, int act, int exp, int tol);
    nChecks++;
    if (act > exp + tol || act < exp - tol) begin
      nFail++;
      $display("FAIL %s at offset %0d: actual %0d expected %0d", tag, t, act, exp);
    end
  endtask

  task automatic advanceTo(int target);
    repeat (target - t) @(negedge clk);
    t = target;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
  endtask

  task automatic testReset();
    rstN  = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0, 0);
    check("R1 sample in reset", sample, 100, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 busy after reset", busy, 0, 0);
    check("R1 done after reset", done, 0, 0);
    check("R1 sample after reset", sample, 100, 0);
  endtask

  task automatic testFullPlay();
    int prev;
    int d;
    int b;
    pulseStart();
    check("R2 busy after start", busy, 1, 0);
    check("R2 sample after start", sample, 100, 0);
    d = DIVS[0];
    prev = 0;
    for (int j = 0; j < 256; j++) begin
      advanceTo(2 * d * j);
      check("R3 table entry", sample, expWave(j), 1);
      if (j >= 1 && j <= 64 && sample < prev)
        check("R5 quarter rise", sample, prev, 0);
      else if (j >= 1 && j <= 64)
        nChecks++;
      prev = sample;
      if (j == 64)  check("R3 peak", sample, 200, 0);
      if (j == 128) check("R3 mid crossing", sample, 100, 0);
      if (j == 192) check("R3 trough", sample, 0, 0);
    end
    advanceTo(512 * d);
    check("R4 period wrap", sample, 100, 0);
    advanceTo(514 * d - 1);
    check("R4 before step 257", sample, 100, 0);
    advanceTo(514 * d);
    check("R4 step 257", sample, expWave(1), 1);
    for (int k = 1; k < 16; k++) begin
      b = k * NC;
      d = DIVS[k];
      advanceTo(b - 1);
      check("R6 still busy before note", busy, 1, 0);
      advanceTo(b);
      check("R6 note start address 0", sample, 100, 0);
      advanceTo(b + 2 * d - 1);
      check("R4 before first step", sample, 100, 0);
      advanceTo(b + 2 * d);
      check("R4 first step", sample, expWave(1), 1);
      advanceTo(b + 128 * d);
      check("R6 peak at note pitch", sample, 200, 0);
      advanceTo(b + 512 * d);
      check("R4 full period", sample, 100, 0);
      advanceTo(b + 514 * d);
      check("R4 repeat step", sample, expWave(1), 1);
    end
    advanceTo(16 * NC - 1);
    check("R7 busy before end", busy, 1, 0);
    check("R7 no early done", done, 0, 0);
    advanceTo(16 * NC);
    check("R7 busy falls", busy, 0, 0);
    check("R7 done pulse", done, 1, 0);
    check("R7 sample mid", sample, 100, 0);
    advanceTo(16 * NC + 1);
    check("R7 done one cycle", done, 0, 0);
    check("R7 sample stays mid", sample, 100, 0);
  endtask

  task automatic testRestart();
    pulseStart();
    advanceTo(NC + 5);
    check("R8 busy in note 1", busy, 1, 0);
    pulseStart();
    check("R8 busy after restart", busy, 1, 0);
    check("R8 address 0 after restart", sample, 100, 0);
    advanceTo(2 * DIVS[0] * 64);
    check("R8 note 0 pitch after restart", sample, 200, 0);
    advanceTo(NC + 2 * DIVS[1] * 64);
    check("R8 note 1 pitch after restart", sample, 200, 0);
    advanceTo(16 * NC);
    check("R8 done after restarted tune", done, 1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    testFullPlay();
    testRestart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule